// File: doc/BRIEF.md
# Snoopy MSI Coherence Controller

This block keeps the coherence state of every sector in one processor's local cache, in a system where two caches share one memory bus. Each sector is Invalid, Shared or Modified, and every sector leaves reset Invalid. The cache's own miss and hit logic reports local events as single-cycle decoded strobes: write hit, read miss and write miss. The logic that watches the other cache's bus traffic reports snoop hits on a read or on a write as two more strobes.

Local misses and upgrades ask for the shared bus with a request/grant pair. Once the arbiter grants the bus, the block drives a bus operation and the sector number. It then waits for memory to signal the end of the transfer, holding a fill flag high while a sector is read in. A snoop that hits a sector held Modified raises an address-retry line toward the other cache. The block then writes the sector back, pulses a write-back-done flag, drops the retry and downgrades the sector. A query port returns the state of any sector one cycle later.

Top module: `snoopy_msi_ctrl`

## Requirements
- R1: After reset every sector reads Invalid (code 0; Shared is 1 and Modified is 2), and all of the following hold. bus_req, addr_retry, fill_busy, loc_done and wb_done are low, bus_op is idle (0) and loc_ready is high.
- R2: A read miss accepted while ready raises bus_req on the next cycle. Once the bus is granted, bus_op shows read (1) with the sector number and fill_busy goes high. On the cycle after mem_done, loc_done pulses, fill_busy and bus_req drop, and the sector becomes Shared.
- R3: A write miss follows the same sequence as a read miss with bus_op read-for-ownership (2), and the sector becomes Modified.
- R4: A write hit on a Shared sector requests the bus. After the grant, bus_op shows invalidate (3) for exactly one cycle without waiting for mem_done and without raising fill_busy. Then loc_done pulses and the sector becomes Modified.
- R5: A write hit on a Modified sector pulses loc_done on the next cycle, does not request the bus and leaves the sector Modified.
- R6: A snoop write hit on a Shared sector makes it Invalid without raising addr_retry or bus_req.
- R7: A snoop read hit on a Shared sector, or any snoop on an Invalid sector, leaves the state unchanged and raises neither addr_retry nor bus_req.
- R8: A snoop hit on a Modified sector raises addr_retry and bus_req on the next cycle. After the grant, bus_op shows write-back (4) with that sector. On the cycle after mem_done, wb_done pulses and addr_retry drops in the same cycle. The sector then becomes Shared after a snoop read, or Invalid after a snoop write.
- R9: A snoop that arrives while a local request waits for the grant is served first, and the pending request then resumes. If a snoop write invalidates the sector of a pending upgrade, that request is issued as read-for-ownership (2) instead of invalidate.
- R10: Local strobes have an effect only while loc_ready is high and no snoop strobe is present in the same cycle. A dropped strobe gives no loc_done, no bus request and no state change.
- R11: q_state shows the state of the sector on q_sector one cycle after that sector is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_wr_hit | input | 1 | Local write hit strobe |
| ev_rd_miss | input | 1 | Local read miss strobe |
| ev_wr_miss | input | 1 | Local write miss strobe |
| loc_sector | input | AW | Sector of the local event |
| loc_ready | output | 1 | Controller idle, local strobes accepted |
| loc_done | output | 1 | Local operation finished (one cycle) |
| snp_rd_hit | input | 1 | Other cache reads a sector present here |
| snp_wr_hit | input | 1 | Other cache writes a sector present here |
| snp_sector | input | AW | Sector of the snooped transaction |
| addr_retry | output | 1 | Tells the other requester to retry later |
| bus_req | output | 1 | Request to the memory-bus arbiter |
| bus_gnt | input | 1 | Grant from the arbiter |
| bus_op | output | 3 | Bus operation: 0 idle, 1 read, 2 read-for-ownership, 3 invalidate, 4 write-back |
| bus_sector | output | AW | Sector address driven on the bus |
| mem_done | input | 1 | Memory finished the current transfer |
| fill_busy | output | 1 | High while a sector is being read from memory |
| wb_done | output | 1 | Write-back to memory finished (one cycle) |
| q_sector | input | AW | Sector whose state is queried |
| q_state | output | 2 | State of the queried sector |

## Verification
The hardest case is a snoop that arrives while the controller already holds a local request and is waiting for the bus. The write-back has to nest inside the pending request, and a pending upgrade has to become a read-for-ownership when a snoop write takes its sector away. The bench reaches this by holding bus_gnt low after a local strobe, injecting the snoop while bus_req is high, and only then granting the bus. It then checks that the write-back comes first and that the original request follows with the correct operation.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2} msi_t;
  typedef enum logic [2:0] {
    OP_IDLE = 3'd0, OP_READ = 3'd1, OP_READX = 3'd2, OP_INVAL = 3'd3, OP_WBACK = 3'd4
  } bus_op_t;
  typedef enum logic [2:0] {C_IDLE, C_REQ, C_XFER, C_WBREQ, C_WBXFER} ctl_t;
  typedef enum logic [1:0] {P_RD, P_RDX, P_UPG} pend_t;
endpackage

// File: rtl/msi_state_table.sv
module msi_state_table
  import msi_pkg::*;
#(
  parameter int NSECT = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  msi_t          wr_state,
  input  logic [AW-1:0] loc_idx,
  input  logic [AW-1:0] snp_idx,
  input  logic [AW-1:0] q_idx,
  output msi_t          loc_state,
  output msi_t          snp_state,
  output msi_t          q_state
);
  msi_t ent [NSECT];

  for (genvar g = 0; g < NSECT; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) ent[g] <= ST_I;
      else if (wr_en && wr_idx == AW'(g)) ent[g] <= wr_state;
    end
  end

  assign loc_state = ent[loc_idx];
  assign snp_state = ent[snp_idx];

  always_ff @(posedge clk) begin
    if (rst) q_state <= ST_I;
    else     q_state <= ent[q_idx];
  end
endmodule

// File: rtl/msi_ctrl_fsm.sv
module msi_ctrl_fsm
  import msi_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_wr_hit,
  input  logic          ev_rd_miss,
  input  logic          ev_wr_miss,
  input  logic [AW-1:0] loc_idx,
  input  msi_t          loc_state,
  input  logic          snp_rd_hit,
  input  logic          snp_wr_hit,
  input  logic [AW-1:0] snp_idx,
  input  msi_t          snp_state,
  input  logic          bus_gnt,
  input  logic          mem_done,
  output logic          loc_ready,
  output logic          loc_done,
  output logic          addr_retry,
  output logic          bus_req,
  output bus_op_t       bus_op,
  output logic [AW-1:0] bus_sector,
  output logic          fill_busy,
  output logic          wb_done,
  output logic          wr_en,
  output logic [AW-1:0] wr_idx,
  output msi_t          wr_state
);
  ctl_t          st;
  pend_t         pend_op;
  logic [AW-1:0] pend_idx;
  logic [AW-1:0] wb_idx;
  logic          wb_to_s;
  logic          wb_ret;

  logic snp_any, loc_any;
  assign snp_any   = snp_rd_hit | snp_wr_hit;
  assign loc_any   = ev_wr_hit | ev_rd_miss | ev_wr_miss;
  assign loc_ready = (st == C_IDLE);

  always_comb begin
    wr_en    = 1'b0;
    wr_idx   = snp_idx;
    wr_state = ST_I;
    if ((st == C_IDLE || st == C_REQ) && snp_wr_hit && snp_state == ST_S) begin
      wr_en = 1'b1;
    end else if (st == C_XFER && (pend_op == P_UPG || mem_done)) begin
      wr_en    = 1'b1;
      wr_idx   = pend_idx;
      wr_state = (pend_op == P_RD) ? ST_S : ST_M;
    end else if (st == C_WBXFER && mem_done) begin
      wr_en    = 1'b1;
      wr_idx   = wb_idx;
      wr_state = wb_to_s ? ST_S : ST_I;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= C_IDLE;
      pend_op    <= P_RD;
      pend_idx   <= '0;
      wb_idx     <= '0;
      wb_to_s    <= 1'b0;
      wb_ret     <= 1'b0;
      bus_req    <= 1'b0;
      bus_op     <= OP_IDLE;
      bus_sector <= '0;
      fill_busy  <= 1'b0;
      addr_retry <= 1'b0;
      wb_done    <= 1'b0;
      loc_done   <= 1'b0;
    end else begin
      loc_done <= 1'b0;
      wb_done  <= 1'b0;
      case (st)
        C_IDLE: begin
          if (snp_any) begin
            if (snp_state == ST_M) begin
              addr_retry <= 1'b1;
              bus_req    <= 1'b1;
              wb_idx     <= snp_idx;
              wb_to_s    <= snp_rd_hit;
              wb_ret     <= 1'b0;
              st         <= C_WBREQ;
            end
          end else if (ev_wr_hit && loc_state == ST_M) begin
            loc_done <= 1'b1;
          end else if (loc_any) begin
            pend_idx <= loc_idx;
            if (ev_rd_miss)                        pend_op <= P_RD;
            else if (ev_wr_hit && loc_state == ST_S) pend_op <= P_UPG;
            else                                   pend_op <= P_RDX;
            bus_req <= 1'b1;
            st      <= C_REQ;
          end
        end
        C_REQ: begin
          if (snp_any) begin
            if (snp_state == ST_M) begin
              addr_retry <= 1'b1;
              wb_idx     <= snp_idx;
              wb_to_s    <= snp_rd_hit;
              wb_ret     <= 1'b1;
              st         <= C_WBREQ;
            end else if (snp_wr_hit && snp_idx == pend_idx && pend_op == P_UPG) begin
              pend_op <= P_RDX;
            end
          end else if (bus_gnt) begin
            st         <= C_XFER;
            bus_sector <= pend_idx;
            fill_busy  <= (pend_op != P_UPG);
            case (pend_op)
              P_RD:    bus_op <= OP_READ;
              P_UPG:   bus_op <= OP_INVAL;
              default: bus_op <= OP_READX;
            endcase
          end
        end
        C_XFER: begin
          if (pend_op == P_UPG || mem_done) begin
            st        <= C_IDLE;
            bus_req   <= 1'b0;
            bus_op    <= OP_IDLE;
            fill_busy <= 1'b0;
            loc_done  <= 1'b1;
          end
        end
        C_WBREQ: begin
          if (bus_gnt) begin
            st         <= C_WBXFER;
            bus_op     <= OP_WBACK;
            bus_sector <= wb_idx;
          end
        end
        C_WBXFER: begin
          if (mem_done) begin
            wb_done    <= 1'b1;
            addr_retry <= 1'b0;
            bus_op     <= OP_IDLE;
            bus_req    <= wb_ret;
            st         <= wb_ret ? C_REQ : C_IDLE;
          end
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  AST_FILL_ON_BUS: assert property (@(posedge clk) disable iff (rst)
    fill_busy |-> (bus_req && (bus_op == OP_READ || bus_op == OP_READX))); // R2
  AST_INVAL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (bus_op == OP_INVAL) |=> (bus_op == OP_IDLE)); // R4
  AST_RETRY_UNTIL_WB: assert property (@(posedge clk) disable iff (rst)
    $fell(addr_retry) |-> wb_done); // R8
  AST_WB_FROM_BUS: assert property (@(posedge clk) disable iff (rst)
    wb_done |-> ($past(bus_op) == OP_WBACK)); // R8
  AST_RETRY_NO_FILL: assert property (@(posedge clk) disable iff (rst)
    addr_retry |-> !fill_busy); // R8
  AST_READY_NO_BUS: assert property (@(posedge clk) disable iff (rst)
    loc_ready |-> !bus_req); // R10
  AST_ONE_LOCAL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_wr_hit, ev_rd_miss, ev_wr_miss})); // R10
  AST_ONE_SNOOP: assert property (@(posedge clk) disable iff (rst)
    $onehot0({snp_rd_hit, snp_wr_hit})); // R9
endmodule

// File: rtl/snoopy_msi_ctrl.sv
module snoopy_msi_ctrl
  import msi_pkg::*;
#(
  parameter int NSECT = 8,
  localparam int AW = (NSECT > 1) ? $clog2(NSECT) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ev_wr_hit,
  input  logic          ev_rd_miss,
  input  logic          ev_wr_miss,
  input  logic [AW-1:0] loc_sector,
  output logic          loc_ready,
  output logic          loc_done,
  input  logic          snp_rd_hit,
  input  logic          snp_wr_hit,
  input  logic [AW-1:0] snp_sector,
  output logic          addr_retry,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic [2:0]    bus_op,
  output logic [AW-1:0] bus_sector,
  input  logic          mem_done,
  output logic          fill_busy,
  output logic          wb_done,
  input  logic [AW-1:0] q_sector,
  output logic [1:0]    q_state
);
  msi_t          loc_state, snp_state, q_st;
  logic          wr_en;
  logic [AW-1:0] wr_idx;
  msi_t          wr_state;
  bus_op_t       op;

  msi_state_table #(.NSECT(NSECT), .AW(AW)) u_table (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state),
    .loc_idx(loc_sector), .snp_idx(snp_sector), .q_idx(q_sector),
    .loc_state(loc_state), .snp_state(snp_state), .q_state(q_st)
  );

  msi_ctrl_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst(rst),
    .ev_wr_hit(ev_wr_hit), .ev_rd_miss(ev_rd_miss), .ev_wr_miss(ev_wr_miss),
    .loc_idx(loc_sector), .loc_state(loc_state),
    .snp_rd_hit(snp_rd_hit), .snp_wr_hit(snp_wr_hit),
    .snp_idx(snp_sector), .snp_state(snp_state),
    .bus_gnt(bus_gnt), .mem_done(mem_done),
    .loc_ready(loc_ready), .loc_done(loc_done), .addr_retry(addr_retry),
    .bus_req(bus_req), .bus_op(op), .bus_sector(bus_sector),
    .fill_busy(fill_busy), .wb_done(wb_done),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_state(wr_state)
  );

  assign bus_op  = op;
  assign q_state = q_st;
endmodule

// File: tb/sim_snoopy_msi_ctrl.sv
`timescale 1ns/1ps
module sim_snoopy_msi_ctrl;
  localparam int NSECT = 8;
  localparam int AW = 3;

  logic clk = 0, rst = 1;
  logic ev_wr_hit = 0, ev_rd_miss = 0, ev_wr_miss = 0;
  logic [AW-1:0] loc_sector = '0, snp_sector = '0, q_sector = '0;
  logic snp_rd_hit = 0, snp_wr_hit = 0, bus_gnt = 0, mem_done = 0;
  logic loc_ready, loc_done, addr_retry, bus_req, fill_busy, wb_done;
  logic [2:0] bus_op;
  logic [AW-1:0] bus_sector;
  logic [1:0] q_state;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  snoopy_msi_ctrl #(.NSECT(NSECT)) u0 (
    .clk(clk), .rst(rst), .ev_wr_hit(ev_wr_hit), .ev_rd_miss(ev_rd_miss),
    .ev_wr_miss(ev_wr_miss), .loc_sector(loc_sector), .loc_ready(loc_ready),
    .loc_done(loc_done), .snp_rd_hit(snp_rd_hit), .snp_wr_hit(snp_wr_hit),
    .snp_sector(snp_sector), .addr_retry(addr_retry), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_op(bus_op), .bus_sector(bus_sector),
    .mem_done(mem_done), .fill_busy(fill_busy), .wb_done(wb_done),
    .q_sector(q_sector), .q_state(q_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic state_is(input string tag, input int s, input int exp);
    q_sector = AW'(s);
    @(negedge clk);
    chk(tag, int'(q_state), exp);
  endtask

  // kind: 0 write hit, 1 read miss, 2 write miss
  task automatic local_ev(input int kind, input int s);
    loc_sector = AW'(s);
    ev_wr_hit = (kind == 0); ev_rd_miss = (kind == 1); ev_wr_miss = (kind == 2);
    @(negedge clk);
    ev_wr_hit = 0; ev_rd_miss = 0; ev_wr_miss = 0;
  endtask

  // kind: 0 snoop read, 1 snoop write
  task automatic snoop(input int kind, input int s);
    snp_sector = AW'(s);
    snp_rd_hit = (kind == 0); snp_wr_hit = (kind == 1);
    @(negedge clk);
    snp_rd_hit = 0; snp_wr_hit = 0;
  endtask

  task automatic serve_local(input string tag, input int op, input int s);
    chk({tag, " bus_req"}, int'(bus_req), 1);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk({tag, " bus_op"}, int'(bus_op), op);
    chk({tag, " bus_sector"}, int'(bus_sector), s);
    chk({tag, " fill_busy"}, int'(fill_busy), (op == 3) ? 0 : 1);
    if (op != 3) mem_done = 1;
    @(negedge clk);
    mem_done = 0;
    chk({tag, " loc_done"}, int'(loc_done), 1);
    chk({tag, " fill_busy off"}, int'(fill_busy), 0);
    chk({tag, " bus_req off"}, int'(bus_req), 0);
  endtask

  task automatic serve_wb(input string tag, input int s, input int req_after);
    chk({tag, " retry"}, int'(addr_retry), 1);
    chk({tag, " bus_req"}, int'(bus_req), 1);
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk({tag, " bus_op wb"}, int'(bus_op), 4);
    chk({tag, " bus_sector"}, int'(bus_sector), s);
    chk({tag, " retry held"}, int'(addr_retry), 1);
    mem_done = 1;
    @(negedge clk);
    mem_done = 0;
    chk({tag, " wb_done"}, int'(wb_done), 1);
    chk({tag, " retry low"}, int'(addr_retry), 0);
    chk({tag, " bus_req after"}, int'(bus_req), req_after);
  endtask

  task automatic t_reset;
    chk("R1 bus_req", int'(bus_req), 0);
    chk("R1 retry", int'(addr_retry), 0);
    chk("R1 fill", int'(fill_busy), 0);
    chk("R1 done", int'(loc_done) + int'(wb_done), 0);
    chk("R1 bus_op", int'(bus_op), 0);
    chk("R1 ready", int'(loc_ready), 1);
    for (int s = 0; s < NSECT; s++) state_is("R1 sector invalid", s, 0);
  endtask

  task automatic t_read_miss;
    local_ev(1, 3);
    serve_local("R2 read miss", 1, 3);
    state_is("R2 shared after fill R11", 3, 1);
  endtask

  task automatic t_write_miss;
    local_ev(2, 5);
    serve_local("R3 write miss", 2, 5);
    state_is("R3 modified", 5, 2);
  endtask

  task automatic t_write_hit_m;
    local_ev(0, 5);
    chk("R5 loc_done", int'(loc_done), 1);
    chk("R5 no bus_req", int'(bus_req), 0);
    state_is("R5 stays modified", 5, 2);
  endtask

  task automatic t_upgrade;
    local_ev(0, 3);
    serve_local("R4 upgrade", 3, 3);
    state_is("R4 modified", 3, 2);
  endtask

  task automatic t_snoop_shared;
    local_ev(1, 1);
    serve_local("R6 setup", 1, 1);
    snoop(1, 1);
    chk("R6 no retry", int'(addr_retry), 0);
    chk("R6 no bus_req", int'(bus_req), 0);
    state_is("R6 invalidated", 1, 0);
    local_ev(1, 2);
    serve_local("R7 setup", 1, 2);
    snoop(0, 2);
    chk("R7 no retry", int'(addr_retry), 0);
    chk("R7 no bus_req", int'(bus_req), 0);
    state_is("R7 shared kept", 2, 1);
    snoop(1, 7);
    chk("R7 invalid no retry", int'(addr_retry) + int'(bus_req), 0);
    state_is("R7 invalid kept", 7, 0);
  endtask

  task automatic t_snoop_modified;
    snoop(0, 3);
    serve_wb("R8 snoop read", 3, 0);
    state_is("R8 shared after wb", 3, 1);
    snoop(1, 5);
    serve_wb("R8 snoop write", 5, 0);
    state_is("R8 invalid after wb", 5, 0);
  endtask

  task automatic t_snoop_pending;
    local_ev(0, 2);                 // upgrade pending on sector 2
    chk("R9 pending req", int'(bus_req), 1);
    snoop(1, 2);
    chk("R9 no retry", int'(addr_retry), 0);
    serve_local("R9 upgrade becomes readx", 2, 2);
    state_is("R9 modified", 2, 2);
    local_ev(2, 6);
    serve_local("R9 setup", 2, 6);
    local_ev(1, 0);                 // read miss pending on sector 0
    snoop(0, 6);
    serve_wb("R9 nested wb", 6, 1);
    serve_local("R9 resumed read", 1, 0);
    state_is("R9 pending filled", 0, 1);
    state_is("R9 downgraded", 6, 1);
  endtask

  task automatic t_drop;
    loc_sector = 3'd7; ev_rd_miss = 1;
    snp_sector = 3'd7; snp_rd_hit = 1;
    @(negedge clk);
    ev_rd_miss = 0; snp_rd_hit = 0;
    chk("R10 dropped no req", int'(bus_req), 0);
    @(negedge clk);
    chk("R10 dropped no done", int'(loc_done), 0);
    local_ev(1, 4);
    chk("R10 busy", int'(loc_ready), 0);
    local_ev(2, 7);                 // ignored while busy
    serve_local("R10 first request", 1, 4);
    state_is("R10 ignored sector", 7, 0);
    state_is("R10 served sector", 4, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_read_miss();
    t_write_miss();
    t_write_hit_m();
    t_upgrade();
    t_snoop_shared();
    t_snoop_modified();
    t_snoop_pending();
    t_drop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule